// File: doc/BRIEF.md
# Data Cache Range Maintenance Sequencer

This block turns one data-cache maintenance request into the run of register writes that a data cache's maintenance port expects. A request carries a byte start address, a byte size, a 2-bit operation code and a whole-cache flag. The sequencer rounds the start down to a line boundary. It adds the removed offset to the size, counts the lines touched with the range end exclusive, and walks them one line at a time. In tag-first addressing, each line gets a tag write before its command write. The command register chosen depends on whether the operation discards lines or writes them back.

A combined write-back-and-invalidate uses the invalidate command with the invalidate sub-mode output switched to write-back-before-discard for the length of the request. The sub-mode returns to plain discard before completion is signalled. Any operation that involves write-back holds completion until the cache's flush-busy flag reads clear. A whole-cache request issues one write of the value 1 to the whole-cache register and follows the same mode and wait rules. The request side is a valid/ready handshake, and completion is a one-cycle pulse.

Top module: `dc_range_seq`

## Requirements
- R1: `req_ready_o` is high exactly when the sequencer is idle. A request is taken on a cycle with `req_valid_i` and `req_ready_o` both high, and `req_ready_o` stays low from the next cycle until the cycle in which `done_o` pulses.
- R2: `req_op_i` encodes 1 as invalidate only, 2 as write-back only and 3 as write-back then invalidate. Code 0 produces no writes and pulses `done_o` in the cycle after acceptance.
- R3: Every command write uses a select code on `wr_sel_o`. Codes with bit 0 set use the invalidate selects (1 per line, 3 whole cache). Code 2 uses the write-back selects (2 per line, 4 whole cache).
- R4: For code 3 with work to do, `inv_mode_o` is high from the cycle after acceptance until the cycle before `done_o`, and low in the `done_o` cycle. For every other request `inv_mode_o` stays low.
- R5: The first line address is the start address rounded down to a multiple of LINE_BYTES (default 32), and each later line is LINE_BYTES above the one before.
- R6: The number of lines is ceil((size + start mod LINE_BYTES) / LINE_BYTES). No line past the last byte of the exclusive range is written.
- R7: With TAG_FIRST=1, each line is a write with select 0 carrying the line address, followed in the next cycle by the command write carrying the same address. The writes are back to back from the cycle after acceptance.
- R8: For codes with bit 1 set, `flush_busy_i` is sampled from the cycle after the last write. `done_o` pulses in the cycle after the first sample that reads low.
- R9: For code 1, `done_o` pulses in the cycle right after the last write, whatever the value of `flush_busy_i`.
- R10: With `req_all_i` set and a nonzero code, exactly one write is made with data 1 and select 3 or 4, and the size is ignored.
- R11: A line request of size zero produces no writes, leaves `inv_mode_o` low and pulses `done_o` in the cycle after acceptance.
- R12: `done_o` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Sequencer idle, request can be taken |
| req_all_i | input | 1 | Whole-cache request |
| req_op_i | input | 2 | Operation code (1 inv, 2 write-back, 3 both) |
| req_addr_i | input | ADDR_W | Start byte address |
| req_size_i | input | SIZE_W | Size in bytes |
| wr_en_o | output | 1 | Maintenance register write strobe |
| wr_sel_o | output | 3 | Register select: 0 tag, 1 line inv, 2 line wb, 3 all inv, 4 all wb |
| wr_data_o | output | ADDR_W | Write data (line address or 1) |
| inv_mode_o | output | 1 | Invalidate sub-mode: 1 write back before discard |
| flush_busy_i | input | 1 | Cache reports a write-back in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A wrong line count or alignment shows up as a write list that is too long, too short or shifted, and it is caught at the `done_o` pulse of that request. A sub-mode bit that is left stuck or released early is visible on `inv_mode_o` in the first wrong cycle. A wrong wait decision moves the `done_o` pulse by at least one cycle relative to the busy latency that the bench's cache model chose, or brings it into the inverse case. A stuck state machine drops `req_ready_o` for good and is caught by the per-request cycle limit.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
  typedef enum logic [2:0] {
    SEL_TAG      = 3'd0,
    SEL_LINE_INV = 3'd1,
    SEL_LINE_WB  = 3'd2,
    SEL_ALL_INV  = 3'd3,
    SEL_ALL_WB   = 3'd4
  } sel_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_TAG,
    S_CMD,
    S_ALL,
    S_WAIT
  } state_e;
endpackage

// File: rtl/dcm_range_calc.sv
module dcm_range_calc #(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 16,
  parameter int LINE_BYTES = 32,
  localparam int LSB       = $clog2(LINE_BYTES),
  localparam int SUM_W     = SIZE_W + 2,
  localparam int CNT_W     = SUM_W - LSB
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              zero_o
);
  logic [SUM_W-1:0] sum;

  assign base_o = {addr_i[ADDR_W-1:LSB], {LSB{1'b0}}};
  // offset folded into size, then rounded up to whole lines
  assign sum = {2'b00, size_i} + {{(SUM_W-LSB){1'b0}}, addr_i[LSB-1:0]}
             + SUM_W'(LINE_BYTES - 1);
  assign zero_o  = (size_i == '0);
  assign count_o = zero_o ? '0 : sum[SUM_W-1:LSB];
endmodule

// File: rtl/dcm_line_walker.sv
module dcm_line_walker #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 13,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (load_i) begin
      addr_q <= base_i;
      rem_q  <= count_i;
    end else if (step_i) begin
      addr_q <= addr_q + ADDR_W'(LINE_BYTES);
      rem_q  <= rem_q - 1'b1;
    end
  end

  assign addr_o = addr_q;
  assign last_o = (rem_q == CNT_W'(1));

  // R6: never walk beyond the counted lines
  a_r6_step_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> (rem_q != '0));
  a_r6_load_step_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && step_i));
endmodule

// File: rtl/dcm_seq_ctrl.sv
module dcm_seq_ctrl #(
  parameter int ADDR_W    = 32,
  parameter bit TAG_FIRST = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_all_i,
  input  logic [1:0]        req_op_i,
  input  logic              cnt_zero_i,
  input  logic              flush_busy_i,
  input  logic              last_i,
  input  logic [ADDR_W-1:0] line_addr_i,
  output logic              req_ready_o,
  output logic              load_o,
  output logic              step_o,
  output logic              wr_en_o,
  output logic [2:0]        wr_sel_o,
  output logic [ADDR_W-1:0] wr_data_o,
  output logic              inv_mode_o,
  output logic              done_o
);
  import dcm_pkg::*;

  localparam state_e LINE_START = TAG_FIRST ? S_TAG : S_CMD;

  state_e     state_q, state_d;
  logic [1:0] op_q, op_d;
  logic       mode_q, mode_d;
  logic       done_q, done_d;
  logic       accept, has_work;

  assign accept   = req_valid_i && (state_q == S_IDLE);
  assign has_work = (req_op_i != 2'b00) && (req_all_i || !cnt_zero_i);

  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    mode_d  = mode_q;
    done_d  = 1'b0;
    load_o  = 1'b0;
    step_o  = 1'b0;
    unique case (state_q)
      S_IDLE: if (accept) begin
        if (!has_work) begin
          done_d = 1'b1;
        end else begin
          op_d    = req_op_i;
          mode_d  = (req_op_i == 2'b11);
          load_o  = !req_all_i;
          state_d = req_all_i ? S_ALL : LINE_START;
        end
      end
      S_TAG: state_d = S_CMD;
      S_CMD, S_ALL: begin
        step_o = (state_q == S_CMD);
        if (state_q == S_ALL || last_i) begin
          if (op_q[1]) begin
            state_d = S_WAIT;
          end else begin
            state_d = S_IDLE;
            mode_d  = 1'b0;
            done_d  = 1'b1;
          end
        end else begin
          state_d = LINE_START;
        end
      end
      S_WAIT: if (!flush_busy_i) begin
        state_d = S_IDLE;
        mode_d  = 1'b0;
        done_d  = 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q    <= 2'b00;
      mode_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      mode_q  <= mode_d;
      done_q  <= done_d;
    end
  end

  always_comb begin
    wr_en_o   = 1'b0;
    wr_sel_o  = SEL_TAG;
    wr_data_o = line_addr_i;
    unique case (state_q)
      S_TAG: wr_en_o = 1'b1;
      S_CMD: begin
        wr_en_o  = 1'b1;
        wr_sel_o = op_q[0] ? SEL_LINE_INV : SEL_LINE_WB;
      end
      S_ALL: begin
        wr_en_o   = 1'b1;
        wr_sel_o  = op_q[0] ? SEL_ALL_INV : SEL_ALL_WB;
        wr_data_o = ADDR_W'(1);
      end
      default: ;
    endcase
  end

  assign req_ready_o = (state_q == S_IDLE);
  assign inv_mode_o  = mode_q;
  assign done_o      = done_q;

  // R4: sub-mode already restored when completion is reported
  a_r4_mode_clear_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !inv_mode_o);
  a_r4_mode_only_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_mode_o |-> !req_ready_o);
  // R8: no completion while the cache still reports a flush
  a_r8_hold_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT && flush_busy_i) |=> !done_o);
  // R12: completion only reported from idle
  a_r12_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> req_ready_o);
  // R3: write-back-only never drives an invalidate select
  a_r3_wb_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && op_q == 2'b10) |-> (wr_sel_o != SEL_LINE_INV && wr_sel_o != SEL_ALL_INV));
endmodule

// File: rtl/dc_range_seq.sv
module dc_range_seq #(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 16,
  parameter int LINE_BYTES = 32,
  parameter bit TAG_FIRST  = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_all_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [SIZE_W-1:0] req_size_i,
  output logic              wr_en_o,
  output logic [2:0]        wr_sel_o,
  output logic [ADDR_W-1:0] wr_data_o,
  output logic              inv_mode_o,
  input  logic              flush_busy_i,
  output logic              done_o
);
  import dcm_pkg::*;

  localparam int LSB   = $clog2(LINE_BYTES);
  localparam int CNT_W = SIZE_W + 2 - LSB;

  logic [ADDR_W-1:0] base, line_addr;
  logic [CNT_W-1:0]  count;
  logic              cnt_zero, load, step, last;

  dcm_range_calc #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .LINE_BYTES(LINE_BYTES)) u_calc (
    .addr_i (req_addr_i),
    .size_i (req_size_i),
    .base_o (base),
    .count_o(count),
    .zero_o (cnt_zero)
  );

  dcm_line_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LINE_BYTES(LINE_BYTES)) u_walk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .step_i (step),
    .base_i (base),
    .count_i(count),
    .addr_o (line_addr),
    .last_o (last)
  );

  dcm_seq_ctrl #(.ADDR_W(ADDR_W), .TAG_FIRST(TAG_FIRST)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_all_i   (req_all_i),
    .req_op_i    (req_op_i),
    .cnt_zero_i  (cnt_zero),
    .flush_busy_i(flush_busy_i),
    .last_i      (last),
    .line_addr_i (line_addr),
    .req_ready_o (req_ready_o),
    .load_o      (load),
    .step_o      (step),
    .wr_en_o     (wr_en_o),
    .wr_sel_o    (wr_sel_o),
    .wr_data_o   (wr_data_o),
    .inv_mode_o  (inv_mode_o),
    .done_o      (done_o)
  );

  generate
    if (TAG_FIRST) begin : g_tag_chk
      // R7: a tag write is always followed by its line command, same address
      a_r7_tag_then_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_o && wr_sel_o == SEL_TAG) |=>
          (wr_en_o && (wr_sel_o == SEL_LINE_INV || wr_sel_o == SEL_LINE_WB)
           && $stable(wr_data_o)));
    end else begin : g_no_tag_chk
      a_r7_no_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_o |-> (wr_sel_o != SEL_TAG));
    end
  endgenerate
endmodule

// File: tb/test_dc_range_seq.sv
module test_dc_range_seq;
  localparam int ADDR_W = 32;
  localparam int SIZE_W = 16;
  localparam int LB     = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0, req_all = 1'b0;
  logic [1:0]        req_op = 2'b00;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [SIZE_W-1:0] req_size = '0;
  logic              req_ready, wr_en, inv_mode, done;
  logic [2:0]        wr_sel;
  logic [ADDR_W-1:0] wr_data;
  logic              flush_busy;

  int checks = 0, errors = 0;
  int lat = 0;
  logic force_busy = 1'b0;
  int busy_cnt = 0;

  always #4 clk = ~clk;

  dc_range_seq #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .LINE_BYTES(LB), .TAG_FIRST(1'b1)) i_dc_range_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_all_i(req_all), .req_op_i(req_op), .req_addr_i(req_addr), .req_size_i(req_size),
    .wr_en_o(wr_en), .wr_sel_o(wr_sel), .wr_data_o(wr_data), .inv_mode_o(inv_mode),
    .flush_busy_i(flush_busy), .done_o(done)
  );

  // cache model: write-back-type command keeps the flag up for lat cycles
  always @(posedge clk) begin
    if (wr_en && (wr_sel == 3'd2 || wr_sel == 3'd4 ||
                  (inv_mode && (wr_sel == 3'd1 || wr_sel == 3'd3))))
      busy_cnt <= lat;
    else if (busy_cnt != 0)
      busy_cnt <= busy_cnt - 1;
  end
  assign flush_busy = force_busy || (busy_cnt != 0);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int n_lines(input logic [31:0] a, input int sz);
    if (sz == 0) return 0;
    return (sz + int'(a % LB) + LB - 1) / LB;
  endfunction

  task automatic run_req(input bit all, input logic [1:0] op, input logic [31:0] a,
                         input int sz, input int l, input bit fb);
    int nl, nw, exp_done, widx, bad_wr, bad_mode, bad_rdy, cyc;
    bit work, wb;
    logic [31:0] base, e_data;
    logic [2:0]  e_sel;
    lat = l; force_busy = fb;
    base = a & ~(LB - 1);
    nl = n_lines(a, sz);
    work = (op != 2'b00) && (all || nl != 0);
    nw = !work ? 0 : (all ? 1 : 2 * nl);
    wb = op[1];
    exp_done = !work ? 1 : (wb ? nw + 2 + l : nw + 1);
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready idle", req_ready, 1);
    req_valid = 1'b1; req_all = all; req_op = op; req_addr = a; req_size = SIZE_W'(sz);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    widx = 0; bad_wr = 0; bad_mode = 0; bad_rdy = 0; cyc = 1;
    while (cyc < 4000) begin
      if (wr_en) begin
        if (all) begin
          e_sel = op[0] ? 3'd3 : 3'd4; e_data = 32'd1;
        end else begin
          e_data = base + 32'(LB * (widx / 2));
          e_sel  = (widx % 2 == 0) ? 3'd0 : (op[0] ? 3'd1 : 3'd2);
        end
        if (widx >= nw || wr_sel != e_sel || wr_data != e_data) begin
          bad_wr++;
          $display("  write %0d: sel %0d data %h, expected sel %0d data %h",
                   widx, wr_sel, wr_data, e_sel, e_data);
        end
        widx++;
      end
      if (done) begin
        if (inv_mode) bad_mode++;
        break;
      end
      if (inv_mode != (work && op == 2'b11)) bad_mode++;
      if (req_ready) bad_rdy++;
      @(negedge clk); cyc++;
    end
    chk(widx == nw, all ? "R10 write count" : (nl == 0 ? "R11 write count" : "R6 line count"), widx, nw);
    chk(bad_wr == 0, "R3/R5/R7 write sequence", bad_wr, 0);
    chk(done && cyc == exp_done, wb ? "R8 done timing" : (op == 2'b00 ? "R2 done timing" : "R9 done timing"),
        done ? cyc : -1, exp_done);
    chk(bad_mode == 0, "R4 mode bit", bad_mode, 0);
    chk(bad_rdy == 0, "R1 ready low while busy", bad_rdy, 0);
    @(negedge clk);
    chk(done == 1'b0, "R12 single done pulse", done, 0);
    force_busy = 1'b0;
  endtask

  initial begin
    #200000000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && wr_en == 1'b0 && done == 1'b0 && inv_mode == 1'b0,
        "R1 reset state", {req_ready, wr_en, done, inv_mode}, 4'b1000);
    rst_n = 1'b1;
    // directed corners
    run_req(0, 2'b01, 32'h1000, 64, 0, 0);   // R6 aligned: exactly 2 lines
    run_req(0, 2'b01, 32'h101F, 1, 0, 1);    // R9 last byte of a line, busy forced
    run_req(0, 2'b01, 32'h101F, 2, 0, 0);    // R6 crosses into next line
    run_req(0, 2'b10, 32'h2004, 60, 3, 0);   // R8 wait on busy
    run_req(0, 2'b11, 32'h3010, 100, 5, 0);  // R4 combined op
    run_req(0, 2'b11, 32'h3010, 0, 2, 0);    // R11 size zero
    run_req(0, 2'b00, 32'h4000, 96, 0, 0);   // R2 code zero
    run_req(1, 2'b01, 32'h0, 0, 0, 0);       // R10 whole invalidate
    run_req(1, 2'b10, 32'h5000, 9, 4, 0);    // R10 whole write-back
    run_req(1, 2'b11, 32'h0, 7, 1, 0);       // R10 whole combined
    run_req(0, 2'b10, 32'h6000, 32, 0, 0);   // R8 zero latency
    // constrained random
    for (int i = 0; i < 40; i++) begin
      logic [1:0] op;
      int sz;
      op = ($urandom % 10 == 0) ? 2'b00 : 2'(1 + $urandom % 3);
      sz = ($urandom % 8 == 0) ? 0 : int'($urandom % 200);
      run_req(($urandom % 8) == 0, op, $urandom, sz, int'($urandom % 4), ($urandom % 4) == 0 && op == 2'b01);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule